// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits between the local processor bus and a PCI host interface. It maps local addresses onto PCI bus addresses through three programmable outbound windows. Two of the windows translate. Each of these two holds a 64-bit local base, a 32-bit size/enable word and a 64-bit PCI base. Software writes and reads each of these as 32-bit halves through a small register port. The third window has only a size/enable word. That word is stored and can be read back, but it never takes part in translation.

For each local request, the block compares the address against every enabled window. One clock later it returns a hit flag, the index of the window that matched and the translated PCI address. The bits of the size word above bit 0 form a mask, and its two's complement gives the window length. An all-zero mask stands for the largest window that 32 bits can describe.

Top module: `outbound_xlate`

## Requirements
- R1: After a synchronous reset, every window register reads 0, so every window is disabled; rsp_valid and rsp_hit are 0 on the first cycle after reset.
- R2: Register byte offsets are as follows. Window 0: local base low 0x68, local base high 0x6C, size 0x70, PCI base low 0x74, PCI base high 0x78. Window 1: the same order at 0x7C, 0x80, 0x84, 0x88, 0x8C. Window 2: size at 0x90. A write to an offset is returned unchanged by a read of that offset.
- R3: A write to the low half of a 64-bit base leaves its high half unchanged, and a write to the high half leaves the low half unchanged.
- R4: Bit 0 of a size register enables its window. A window whose bit 0 is 0 never produces a hit.
- R5: The window length is the 32-bit two's complement of the size register with bit 0 forced to 0. An address hits when base <= addr < base + length. This also holds one byte below and at the end of the window.
- R6: When that 32-bit length computes to zero, the window covers 0xFFFFFFFF bytes.
- R7: On a hit, rsp_pci_addr equals PCI base + (addr - local base), and rsp_win gives the window number (0 or 1).
- R8: When both translating windows hit, window 0 is reported.
- R9: On a miss, rsp_hit, rsp_win and rsp_pci_addr are all 0.
- R10: The size register of window 2 (offset 0x90) is stored and read back, but writing it never changes any lookup result.
- R11: The result of a request presented in cycle N appears in cycle N+1, and rsp_valid follows req_valid with that one-cycle delay. A register write in the same cycle as a request affects only later requests.
- R12: Reads of offsets not listed in R2 return 0, and writes to them change no register and no lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 64 | Local address to translate |
| rsp_valid | output | 1 | Lookup result valid (one cycle after request) |
| rsp_hit | output | 1 | A translating window matched |
| rsp_win | output | 2 | Number of the matching window |
| rsp_pci_addr | output | 64 | Translated PCI address |

## Verification
A register write and a lookup can land on the same clock edge. The bench provokes this by presenting a request inside an enabled window in the same cycle as a write that clears that window's enable bit. The response must still report the hit computed from the old settings, and the next request must see the window disabled. Boundary addresses on both sides of each window, the all-zero mask and overlapping windows are each judged against a model of the requirements that the bench keeps from its own writes.

// File: rtl/oxw_pkg.sv
package oxw_pkg;

    parameter int NUM_WIN   = 3;
    parameter int NUM_XLATE = 2;
    parameter int ADDR_W    = 64;
    parameter int DATA_W    = 32;
    parameter int REG_AW    = 8;
    localparam int IDX_W    = $clog2(NUM_WIN);

    localparam int WIN_BASE_OFF = 'h68;
    localparam int WIN_STRIDE   = 'h14;
    localparam int AUX_SIZE_OFF = 'h90;

    typedef enum logic [2:0] {
        F_LBASE_LO = 3'd0,
        F_LBASE_HI = 3'd1,
        F_SIZE     = 3'd2,
        F_PBASE_LO = 3'd3,
        F_PBASE_HI = 3'd4
    } field_e;

    typedef struct packed {
        logic [ADDR_W-1:0] lbase;
        logic [DATA_W-1:0] size_reg;
        logic [ADDR_W-1:0] pbase;
    } win_cfg_t;

    function automatic logic [REG_AW-1:0] reg_off(input int w, input field_e f);
        return REG_AW'(WIN_BASE_OFF + w * WIN_STRIDE + 4 * int'(f));
    endfunction

    function automatic logic [DATA_W-1:0] win_bytes(input logic [DATA_W-1:0] sreg);
        logic [DATA_W-1:0] len;
        len = ~(sreg & ~DATA_W'(1)) + DATA_W'(1);
        if (len == '0) len = '1;
        return len;
    endfunction

endpackage

// File: rtl/oxw_regs.sv
module oxw_regs
    import oxw_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [REG_AW-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output win_cfg_t [NUM_XLATE-1:0]      cfg
);

    win_cfg_t [NUM_XLATE-1:0] cfg_q;
    logic [DATA_W-1:0]        aux_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            aux_q <= '0;
        end else if (wr_en) begin
            for (int w = 0; w < NUM_XLATE; w++) begin
                if (addr == reg_off(w, F_LBASE_LO)) cfg_q[w].lbase[DATA_W-1:0]        <= wdata;
                if (addr == reg_off(w, F_LBASE_HI)) cfg_q[w].lbase[ADDR_W-1:DATA_W]   <= wdata;
                if (addr == reg_off(w, F_SIZE))     cfg_q[w].size_reg                 <= wdata;
                if (addr == reg_off(w, F_PBASE_LO)) cfg_q[w].pbase[DATA_W-1:0]        <= wdata;
                if (addr == reg_off(w, F_PBASE_HI)) cfg_q[w].pbase[ADDR_W-1:DATA_W]   <= wdata;
            end
            if (addr == REG_AW'(AUX_SIZE_OFF)) aux_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < NUM_XLATE; w++) begin
            if (addr == reg_off(w, F_LBASE_LO)) rdata = cfg_q[w].lbase[DATA_W-1:0];
            if (addr == reg_off(w, F_LBASE_HI)) rdata = cfg_q[w].lbase[ADDR_W-1:DATA_W];
            if (addr == reg_off(w, F_SIZE))     rdata = cfg_q[w].size_reg;
            if (addr == reg_off(w, F_PBASE_LO)) rdata = cfg_q[w].pbase[DATA_W-1:0];
            if (addr == reg_off(w, F_PBASE_HI)) rdata = cfg_q[w].pbase[ADDR_W-1:DATA_W];
        end
        if (addr == REG_AW'(AUX_SIZE_OFF)) rdata = aux_q;
    end

    assign cfg = cfg_q;

    for (genvar gw = 0; gw < NUM_XLATE; gw++) begin : g_half_chk
        // R3
        lo_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
            wr_en && addr == reg_off(gw, F_LBASE_LO)
            |=> cfg_q[gw].lbase[ADDR_W-1:DATA_W] == $past(cfg_q[gw].lbase[ADDR_W-1:DATA_W]));
        // R3
        hi_write_keeps_lo_chk: assert property (@(posedge clk) disable iff (rst)
            wr_en && addr == reg_off(gw, F_PBASE_HI)
            |=> cfg_q[gw].pbase[DATA_W-1:0] == $past(cfg_q[gw].pbase[DATA_W-1:0]));
    end

    // R10
    aux_write_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == REG_AW'(AUX_SIZE_OFF) |=> $stable(cfg_q));

endmodule

// File: rtl/oxw_match.sv
module oxw_match
    import oxw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] pci_addr
);

    logic [ADDR_W-1:0] offset;
    logic [DATA_W-1:0] len;
    logic              above_base;
    logic              below_end;

    always_comb begin
        offset     = addr - cfg.lbase;
        len        = win_bytes(cfg.size_reg);
        above_base = addr >= cfg.lbase;
        below_end  = offset < {{(ADDR_W-DATA_W){1'b0}}, len};
        hit        = cfg.size_reg[0] && above_base && below_end;
        pci_addr   = cfg.pbase + offset;
    end

    // R4
    disabled_never_hits_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.size_reg[0] |-> !hit);

    // R5
    hit_above_base_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> addr >= cfg.lbase);

endmodule

// File: rtl/oxw_select.sv
module oxw_select
    import oxw_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  req_valid,
    input  logic [NUM_XLATE-1:0]                  hit_vec,
    input  logic [NUM_XLATE-1:0][ADDR_W-1:0]      pci_vec,
    output logic                                  rsp_valid,
    output logic                                  rsp_hit,
    output logic [IDX_W-1:0]                      rsp_win,
    output logic [ADDR_W-1:0]                     rsp_pci_addr
);

    logic              any_hit;
    logic [IDX_W-1:0]  sel_idx;
    logic [ADDR_W-1:0] sel_addr;

    always_comb begin
        any_hit  = |hit_vec;
        sel_idx  = '0;
        sel_addr = '0;
        for (int i = NUM_XLATE - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_idx  = IDX_W'(i);
                sel_addr = pci_vec[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_win      <= '0;
            rsp_pci_addr <= '0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_hit      <= req_valid && any_hit;
            rsp_win      <= (req_valid && any_hit) ? sel_idx  : '0;
            rsp_pci_addr <= (req_valid && any_hit) ? sel_addr : '0;
        end
    end

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid && !rsp_hit);

    // R11
    one_cycle_latency_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> rsp_valid == $past(req_valid));

    // R8
    lowest_window_wins_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(req_valid && hit_vec[0]) |-> rsp_hit && rsp_win == '0);

    // R9
    miss_is_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_hit |-> rsp_win == '0 && rsp_pci_addr == '0);

    // R11
    hit_implies_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

endmodule

// File: rtl/outbound_xlate.sv
module outbound_xlate
    import oxw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [IDX_W-1:0]   rsp_win,
    output logic [ADDR_W-1:0]  rsp_pci_addr
);

    win_cfg_t [NUM_XLATE-1:0]             cfg;
    logic [NUM_XLATE-1:0]                 hit_vec;
    logic [NUM_XLATE-1:0][ADDR_W-1:0]     pci_vec;

    oxw_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    for (genvar g = 0; g < NUM_XLATE; g++) begin : g_win
        oxw_match u_match (
            .clk      (clk),
            .rst      (rst),
            .cfg      (cfg[g]),
            .addr     (req_addr),
            .hit      (hit_vec[g]),
            .pci_addr (pci_vec[g])
        );
    end

    oxw_select u_sel (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .hit_vec      (hit_vec),
        .pci_vec      (pci_vec),
        .rsp_valid    (rsp_valid),
        .rsp_hit      (rsp_hit),
        .rsp_win      (rsp_win),
        .rsp_pci_addr (rsp_pci_addr)
    );

endmodule

// File: tb/sim_outbound_xlate.sv
module sim_outbound_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [1:0]  rsp_win;
    logic [63:0] rsp_pci_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] m_lb [2];
    logic [63:0] m_pb [2];
    logic [31:0] m_sz [2];
    logic [31:0] m_aux;

    always #5 clk = ~clk;

    outbound_xlate u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_win(rsp_win), .rsp_pci_addr(rsp_pci_addr)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void m_write(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h68: m_lb[0][31:0]  = d;
            8'h6C: m_lb[0][63:32] = d;
            8'h70: m_sz[0]        = d;
            8'h74: m_pb[0][31:0]  = d;
            8'h78: m_pb[0][63:32] = d;
            8'h7C: m_lb[1][31:0]  = d;
            8'h80: m_lb[1][63:32] = d;
            8'h84: m_sz[1]        = d;
            8'h88: m_pb[1][31:0]  = d;
            8'h8C: m_pb[1][63:32] = d;
            8'h90: m_aux          = d;
            default: ;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h68: return m_lb[0][31:0];
            8'h6C: return m_lb[0][63:32];
            8'h70: return m_sz[0];
            8'h74: return m_pb[0][31:0];
            8'h78: return m_pb[0][63:32];
            8'h7C: return m_lb[1][31:0];
            8'h80: return m_lb[1][63:32];
            8'h84: return m_sz[1];
            8'h88: return m_pb[1][31:0];
            8'h8C: return m_pb[1][63:32];
            8'h90: return m_aux;
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_lookup(input logic [63:0] a, output logic h,
                            output logic [1:0] w, output logic [63:0] p);
        h = 1'b0; w = 2'd0; p = 64'd0;
        for (int i = 1; i >= 0; i--) begin
            logic [31:0] len;
            logic [63:0] off;
            len = 32'd0 - (m_sz[i] & 32'hFFFF_FFFE);
            if (len == 32'd0) len = 32'hFFFF_FFFF;
            off = a - m_lb[i];
            if (m_sz[i][0] && a >= m_lb[i] && off < {32'd0, len}) begin
                h = 1'b1; w = 2'(i); p = m_pb[i] + off;
            end
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        m_write(a, d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk($sformatf("%s rd[%h]", tag, a), 64'(reg_rdata), 64'(m_read(a)));
    endtask

    task automatic look_chk(input logic [63:0] a, input string tag);
        logic h; logic [1:0] w; logic [63:0] p;
        m_lookup(a, h, w, p);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " hit"},   64'(rsp_hit),   64'(h));
        chk({tag, " win"},   64'(rsp_win),   64'(w));
        chk({tag, " pci"},   rsp_pci_addr,   p);
    endtask

    task automatic t_reset;
        logic [7:0] offs [11] = '{8'h68, 8'h6C, 8'h70, 8'h74, 8'h78, 8'h7C,
                                 8'h80, 8'h84, 8'h88, 8'h8C, 8'h90};
        chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk("R1 rsp_hit after reset", 64'(rsp_hit), 64'd0);
        foreach (offs[i]) begin
            @(negedge clk);
            reg_addr = offs[i];
            #1;
            chk("R1 reset readback", 64'(reg_rdata), 64'd0);
        end
        look_chk(64'h0, "R1 R9 miss at 0");
        look_chk(64'hFFFF_FFFF_FFFF_FFFF, "R1 R9 miss at top");
    endtask

    task automatic t_readback;
        logic [7:0] offs [11] = '{8'h68, 8'h6C, 8'h70, 8'h74, 8'h78, 8'h7C,
                                 8'h80, 8'h84, 8'h88, 8'h8C, 8'h90};
        foreach (offs[i]) wr(offs[i], 32'hA5C3_0000 | {24'd0, offs[i]} << 4);
        foreach (offs[i]) rd_chk(offs[i], "R2");
        foreach (offs[i]) wr(offs[i], 32'h0);
    endtask

    task automatic t_halves;
        wr(8'h6C, 32'h0000_0001);
        wr(8'h68, 32'h0000_0000);
        rd_chk(8'h6C, "R3 lo write keeps hi");
        wr(8'h78, 32'h0000_DEAD);
        wr(8'h74, 32'h8000_0000);
        rd_chk(8'h78, "R3 pci lo keeps hi");
        wr(8'h6C, 32'h0000_0001);
        wr(8'h68, 32'h0000_0000);
        wr(8'h78, 32'h0000_DEAD);
        rd_chk(8'h74, "R3 pci hi keeps lo");
        rd_chk(8'h68, "R3 hi keeps lo");
    endtask

    task automatic t_basic;
        wr(8'h70, 32'hFFFF_0001);
        look_chk(64'h1_0000_1234, "R7 translate w0");
        look_chk(64'h1_0000_FFFF, "R5 last byte");
        look_chk(64'h1_0001_0000, "R5 end miss");
        look_chk(64'h0_FFFF_FFFF, "R5 below base");
    endtask

    task automatic t_disable;
        wr(8'h70, 32'hFFFF_0000);
        look_chk(64'h1_0000_1234, "R4 disabled miss");
        wr(8'h70, 32'hFFFF_0001);
    endtask

    task automatic t_full;
        wr(8'h80, 32'h0000_0002);
        wr(8'h7C, 32'h0000_0000);
        wr(8'h84, 32'h0000_0001);
        wr(8'h88, 32'h0000_1000);
        wr(8'h8C, 32'h0000_0010);
        look_chk(64'h2_0000_0000, "R6 R7 w1 base");
        look_chk(64'h2_FFFF_FFFE, "R6 full last");
        look_chk(64'h2_FFFF_FFFF, "R6 full end miss");
    endtask

    task automatic t_priority;
        wr(8'h6C, 32'h0000_0002);
        look_chk(64'h2_0000_0010, "R8 overlap w0");
        look_chk(64'h2_0002_0000, "R8 only w1");
    endtask

    task automatic t_win2;
        wr(8'h90, 32'h0000_0001);
        rd_chk(8'h90, "R10 aux readback");
        look_chk(64'h5_0000_0000, "R10 aux no window");
        look_chk(64'h2_0000_0010, "R10 aux no effect");
    endtask

    task automatic t_same_cycle;
        logic h; logic [1:0] w; logic [63:0] p;
        m_lookup(64'h2_0000_0010, h, w, p);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 64'h2_0000_0010;
        reg_wr = 1'b1; reg_addr = 8'h70; reg_wdata = 32'h0;
        @(negedge clk);
        m_write(8'h70, 32'h0);
        req_valid = 1'b0; reg_wr = 1'b0;
        chk("R11 same cycle hit", 64'(rsp_hit), 64'(h));
        chk("R11 same cycle win", 64'(rsp_win), 64'(w));
        chk("R11 same cycle pci", rsp_pci_addr, p);
        @(negedge clk);
        chk("R11 valid drops", 64'(rsp_valid), 64'd0);
        look_chk(64'h2_0000_0010, "R11 after write");
    endtask

    task automatic t_unmapped;
        wr(8'h94, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h6A, 32'hFFFF_FFFF);
        wr(8'h64, 32'hFFFF_FFFF);
        rd_chk(8'h94, "R12");
        rd_chk(8'h00, "R12");
        rd_chk(8'h6A, "R12");
        rd_chk(8'h68, "R12 neighbour");
        rd_chk(8'h6C, "R12 neighbour");
        look_chk(64'h2_0000_0010, "R12 lookup unchanged");
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_lb[i] = '0; m_pb[i] = '0; m_sz[i] = '0;
        end
        m_aux = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readback();
        t_halves();
        t_basic();
        t_disable();
        t_full();
        t_priority();
        t_win2();
        t_same_cycle();
        t_unmapped();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule